// File: doc/BRIEF.md
# Two-Wire EEPROM Page Write Slave

This block is the write side of a small serial EEPROM that sits on a two-wire bus as a slave. It watches already-synchronized samples of the clock and data lines and finds start and stop conditions. It checks the control byte and takes a word address into its pointer. It then collects one or more data bytes into an eight-entry page buffer, acknowledging each accepted byte by pulling the data line low.

When a stop follows at least one data byte, an internally timed write cycle begins. It lasts a fixed, parameterized number of clock cycles. During that time the block acknowledges nothing, so a bus master can poll it with control bytes until it answers. When the cycle ends, only the buffer slots that the transaction filled are copied into the 128-byte array. A side port reads the array combinationally so that its contents can be inspected.

Top module: `eeprom_page_writer`

## Requirements
- R1: A start is the data line falling while the clock line stays high, and a stop is the data line rising while the clock line stays high. A start at any point discards the transfer in progress and expects a new control byte, and no write results from the discarded transfer.
- R2: The first byte after a start is a control byte, sent MSB first. Bits 7..4 must equal 1010 and bit 0 (read/write) must be 0. Bits 3..1 are don't-care, and a matching byte is acknowledged.
- R3: An acknowledge pulls the data line low from the clock fall after the eighth bit of a byte until the clock fall after the ninth clock. The pull is never active outside that window.
- R4: A control byte with the wrong device code or with bit 0 = 1 is not acknowledged. No later byte is acknowledged until the next start, and a stop after it starts no write.
- R5: The byte after an accepted control byte is acknowledged and loaded into the word address pointer. Bit 7 of the address byte is ignored.
- R6: Each data byte is acknowledged and stored at the buffer slot given by pointer bits 2..0. Those bits then advance by one modulo 8 while bits 6..3 stay fixed, so a ninth or later byte overwrites the slot written eight bytes earlier.
- R7: A stop after one or more data bytes sets busy for exactly WRITE_CYCLES clock cycles. When busy falls, the array holds each received slot's latest byte at address {pointer bits 6..3, slot}, and every other address is unchanged.
- R8: While busy is high, no byte is acknowledged, including a matching write control byte. A control byte sent after busy has fallen is acknowledged.
- R9: A stop after only a control byte, or after a control byte and an address, starts no write cycle and leaves the array unchanged.
- R10: After reset every array byte reads 0xFF, busy and the data-line pull are low, and the inspection port returns the byte at its address in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized bus clock sample |
| sda_i | input | 1 | Synchronized bus data sample (wired-AND line) |
| sda_pull_o | output | 1 | Enables the pull-down on the bus data line |
| busy_o | output | 1 | High during the internal write cycle |
| peek_addr_i | input | 7 | Inspection read address |
| peek_data_o | output | 8 | Array byte at peek_addr_i |

## Verification
The assertions rely on a well-behaved master on the inputs. Data changes only while the clock is low, except when it forms a start or a stop. Each line level is held for more than one system clock. The master releases the data line during every ninth clock, so a stop can never coincide with an active acknowledge. The bench's bus-master tasks keep to this by holding each quarter of a bit for several clocks and modelling the data line as the AND of master and slave. Random transfers vary only the byte values, the address, the don't-care bits and the byte count.

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
  parameter int MEM_BYTES = 128,
  parameter int PAGE_BYTES = 8,
  parameter int WRITE_CYCLES = 300,
  parameter logic [3:0] DEV_CODE = 4'b1010,
  localparam int AW = $clog2(MEM_BYTES),
  localparam int PW = $clog2(PAGE_BYTES),
  localparam int CW = $clog2(WRITE_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_pull_o,
  output logic          busy_o,
  input  logic [AW-1:0] peek_addr_i,
  output logic [7:0]    peek_data_o
);

  typedef enum logic [2:0] {P_IDLE, P_CTRL, P_ADDR, P_DATA, P_SKIP} phase_t;

  phase_t              phase;
  logic                scl_q, sda_q;
  logic [3:0]          bitcnt;
  logic [7:0]          shreg;
  logic [AW-1:0]       ptr;
  logic [7:0]          pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pvalid;
  logic [7:0]          mem [MEM_BYTES];
  logic [CW-1:0]       tmr;

  wire start_c  = scl_q & scl_i & sda_q & ~sda_i;
  wire stop_c   = scl_q & scl_i & ~sda_q & sda_i;
  wire rise     = ~scl_q & scl_i;
  wire fall     = scl_q & ~scl_i;
  wire byte_end = fall && bitcnt == 4'd8;
  wire ctrl_ok  = shreg[7:4] == DEV_CODE && !shreg[0] && !busy_o;
  wire commit   = tmr == CW'(1);

  assign busy_o      = tmr != '0;
  assign peek_data_o = mem[peek_addr_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q      <= 1'b1;
      sda_q      <= 1'b1;
      phase      <= P_IDLE;
      bitcnt     <= '0;
      shreg      <= '0;
      ptr        <= '0;
      pvalid     <= '0;
      sda_pull_o <= 1'b0;
      tmr        <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= '0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (busy_o) tmr <= tmr - 1'b1;
      if (start_c) begin
        phase      <= P_CTRL;
        bitcnt     <= '0;
        sda_pull_o <= 1'b0;
      end else if (stop_c) begin
        phase      <= P_IDLE;
        sda_pull_o <= 1'b0;
        if (phase == P_DATA && |pvalid && !busy_o) tmr <= CW'(WRITE_CYCLES);
      end else if (phase != P_IDLE) begin
        if (rise && bitcnt < 4'd8) begin
          shreg  <= {shreg[6:0], sda_i};
          bitcnt <= bitcnt + 4'd1;
        end else if (rise && bitcnt == 4'd8) begin
          bitcnt <= 4'd9;
        end else if (fall && bitcnt == 4'd9) begin
          bitcnt     <= '0;
          sda_pull_o <= 1'b0;
        end else if (byte_end) begin
          case (phase)
            P_CTRL: begin
              phase      <= ctrl_ok ? P_ADDR : P_SKIP;
              sda_pull_o <= ctrl_ok;
            end
            P_ADDR: begin
              ptr        <= shreg[AW-1:0];
              pvalid     <= '0;
              phase      <= P_DATA;
              sda_pull_o <= 1'b1;
            end
            P_DATA: begin
              pbuf[ptr[PW-1:0]]   <= shreg;
              pvalid[ptr[PW-1:0]] <= 1'b1;
              ptr[PW-1:0]         <= ptr[PW-1:0] + 1'b1;
              sda_pull_o          <= 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
    end else if (commit) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (pvalid[i]) mem[{ptr[AW-1:PW], PW'(i)}] <= pbuf[i];
    end
  end

  a_r3_ack_window: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull_o |-> (bitcnt == 4'd8 || bitcnt == 4'd9));

  a_r8_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !sda_pull_o);

  a_r6_page_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_end && phase == P_DATA) |=>
      (ptr[AW-1:PW] == $past(ptr[AW-1:PW]) &&
       ptr[PW-1:0] == PW'($past(ptr[PW-1:0]) + 1'b1)));

  a_r7_write_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_c && phase == P_DATA && |pvalid && !busy_o) |=> busy_o);

  a_r9_no_write_without_data: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_c && !busy_o && phase != P_DATA) |=> !busy_o);

endmodule

// File: tb/eeprom_page_writer_tb.sv
module eeprom_page_writer_tb_top;
  localparam int WR = 300;
  localparam int Q  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [6:0] peek_addr = '0;
  wire  [7:0] peek_data;
  wire  sda_pull, busy;
  wire  sda_line = m_sda & ~sda_pull;

  int total = 0, fails = 0;
  int cur_busy = 0, last_busy = 0;
  logic [7:0] ref_mem [128];
  logic [7:0] dq [16];

  always #2 clk = ~clk;

  eeprom_page_writer #(.WRITE_CYCLES(WR)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .busy_o(busy),
    .peek_addr_i(peek_addr), .peek_data_o(peek_data));

  always @(negedge clk) begin
    if (busy) cur_busy++;
    else if (cur_busy != 0) begin last_busy = cur_busy; cur_busy = 0; end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wt(int n); repeat (n) @(negedge clk); endtask

  task automatic m_start();
    m_sda = 1'b1; wt(Q); m_scl = 1'b1; wt(Q); m_sda = 1'b0; wt(Q); m_scl = 1'b0; wt(Q);
  endtask

  task automatic m_stop();
    m_sda = 1'b0; wt(Q); m_scl = 1'b1; wt(Q); m_sda = 1'b1; wt(Q);
  endtask

  task automatic send_byte(logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wt(Q); m_scl = 1'b1; wt(2*Q); m_scl = 1'b0; wt(Q);
    end
    m_sda = 1'b1; wt(Q); m_scl = 1'b1; wt(Q);
    ack = !sda_line;
    wt(Q); m_scl = 1'b0; wt(Q);
  endtask

  function automatic void model_write(logic [7:0] addr, int n);
    logic [7:0] pb [8];
    bit valid [8];
    logic [2:0] idx = addr[2:0];
    for (int i = 0; i < 8; i++) valid[i] = 0;
    for (int i = 0; i < n; i++) begin pb[idx] = dq[i]; valid[idx] = 1; idx = idx + 3'd1; end
    for (int i = 0; i < 8; i++) if (valid[i]) ref_mem[{addr[6:3], i[2:0]}] = pb[i];
  endfunction

  task automatic do_write(logic [7:0] ctrl, logic [7:0] addr, int n, output bit all_ack);
    bit a;
    m_start();
    send_byte(ctrl, a); all_ack = a;
    send_byte(addr, a); all_ack &= a;
    for (int i = 0; i < n; i++) begin send_byte(dq[i], a); all_ack &= a; end
    m_stop();
  endtask

  task automatic wait_ready(output int polls);
    bit a;
    polls = 0;
    forever begin
      m_start();
      send_byte(8'hA0, a);
      if (a) begin m_stop(); break; end
      polls++;
      if (polls > 100) break;
    end
  endtask

  task automatic verify_mem(string req, string what);
    int bad = 0, bad_addr = 0, act = 0, exp = 0;
    for (int a = 0; a < 128; a++) begin
      peek_addr = a[6:0]; #1;
      if (peek_data !== ref_mem[a]) begin
        if (bad == 0) begin bad_addr = a; act = peek_data; exp = ref_mem[a]; end
        bad++;
      end
    end
    if (bad != 0) $display("  first mismatch at address %0d", bad_addr);
    chk(bad == 0, req, what, act, exp);
  endtask

  task automatic full_write(string req, logic [7:0] ctrl, logic [7:0] addr, int n);
    bit ok;
    int polls;
    do_write(ctrl, addr, n, ok);
    chk(ok, "R3", {req, " all bytes acknowledged"}, ok, 1);
    chk(busy, "R7", {req, " busy after stop"}, busy, 1);
    wait_ready(polls);
    chk(polls > 0, "R8", {req, " no ack while busy"}, polls, 1);
    chk(last_busy == WR, "R7", {req, " busy length"}, last_busy, WR);
    model_write(addr, n);
    verify_mem("R7", {req, " array contents"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    bit a, ok;
    int polls;
    void'($urandom(32'd1234));
    for (int i = 0; i < 128; i++) ref_mem[i] = 8'hFF;
    wt(5); rst_n = 1'b1; wt(3);

    chk(!busy, "R10", "busy after reset", busy, 0);
    chk(!sda_pull, "R10", "pull after reset", sda_pull, 0);
    verify_mem("R10", "array after reset");

    dq[0] = 8'h3C;
    full_write("R2 byte write", 8'hA0, 8'h15, 1);

    for (int i = 0; i < 8; i++) dq[i] = 8'(8'h50 + i);
    full_write("R2 page dc bits", 8'hAE, 8'h40, 8);

    for (int i = 0; i < 11; i++) dq[i] = 8'(8'h90 + i);
    full_write("R6 wrap", 8'hA2, 8'h2D, 11);

    dq[0] = 8'h77;
    full_write("R5 addr bit7", 8'hA0, 8'h95, 1);

    m_start(); send_byte(8'hB0, a);
    chk(!a, "R4", "wrong code acknowledged", a, 0);
    send_byte(8'h10, a);
    chk(!a, "R4", "byte after wrong code acknowledged", a, 0);
    send_byte(8'h22, a); m_stop(); wt(2);
    chk(!busy, "R4", "write after wrong code", busy, 0);

    m_start(); send_byte(8'hA1, a);
    chk(!a, "R4", "read bit acknowledged", a, 0);
    m_stop(); wt(2);
    chk(!busy, "R4", "write after read control", busy, 0);

    m_start(); send_byte(8'hA0, a); send_byte(8'h33, a);
    chk(a, "R5", "address acknowledged", a, 1);
    m_stop(); wt(2);
    chk(!busy, "R9", "stop after address only", busy, 0);
    m_start(); send_byte(8'hA0, a); m_stop(); wt(2);
    chk(!busy, "R9", "stop after control only", busy, 0);
    verify_mem("R9", "array unchanged without data");

    m_start(); send_byte(8'hA0, a); send_byte(8'h60, a);
    send_byte(8'hEE, a); send_byte(8'hEF, a);
    m_start(); m_stop(); wt(2);
    chk(!busy, "R1", "aborted transfer started write", busy, 0);
    verify_mem("R1", "array unchanged after abort");

    m_start(); send_byte(8'hA0, a); send_byte(8'h68, a); send_byte(8'hDD, a);
    dq[0] = 8'h5A;
    do_write(8'hA0, 8'h70, 1, ok);
    chk(ok, "R1", "write after repeated start acknowledged", ok, 1);
    wait_ready(polls);
    model_write(8'h70, 1);
    verify_mem("R1", "only second transfer committed");

    for (int t = 0; t < 30; t++) begin
      logic [7:0] ctrl = {4'b1010, 3'($urandom), 1'b0};
      logic [7:0] addr = 8'($urandom);
      int n = 1 + ($urandom % 12);
      for (int i = 0; i < n; i++) dq[i] = 8'($urandom);
      full_write("R6 random", ctrl, addr, n);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule